// File: doc/BRIEF.md
# Level-Encoded Two-Wire Word Link

This block carries an N-bit word from a sender to a receiver over two wires per bit, a value wire and a toggle wire. Each new word moves exactly one wire of every bit. A bit whose value changes moves its value wire. A bit whose value repeats moves its toggle wire instead. Because of this, the exclusive-OR of a bit's two wires flips on every transfer. That flip tells the receiver that the bit has arrived, and no separate strobe wire is needed.

The sending half and the receiving half both run on one clock. The top module brings both wire pairs out to ports, so the wires between the two halves can be delayed, reordered or looped straight back outside the block. The sender offers one word at a time. Its ready output stays low from the accepted word until the receiver has reported that word complete. The receiver flips its expected parity once every bit shows the new parity. It then captures the word from the value wires and pulses a completion strobe.

Top module: `ledr_link`

## Requirements
- R1: After reset, tx_data, tx_phase and out_word are all zero, out_done is 0 and in_ready is 1.
- R2: A word is accepted on a rising clock edge where in_valid and in_ready are both 1. From the next cycle on, tx_data equals that word.
- R3: For every accepted word, each bit toggles exactly one of its two wires, tx_data[i] or tx_phase[i], never both and never neither.
- R4: When a bit's new value equals its previous value, only tx_phase[i] toggles. Sending the same word twice in a row therefore leaves tx_data unchanged and inverts all of tx_phase.
- R5: in_ready is 0 from the cycle after an accept until the cycle after the matching out_done pulse, and it is 1 again in that following cycle.
- R6: in_valid while in_ready is 0 is ignored: tx_data, tx_phase and the delivered words stay as they were.
- R7: The receiver tracks a parity bit, which is 0 after reset. It declares a word complete only when rx_data[i] XOR rx_phase[i] differs from that bit for every i. While any bit still shows the old parity, out_done stays 0.
- R8: out_done pulses high for one cycle, in the cycle after completion is seen. out_word then holds the rx_data value present at completion, and it keeps that value until the next completion.
- R9: Words come out on out_word in the order they were accepted, including repeated identical words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | W | Word offered to the sender |
| in_valid | input | 1 | Sender input strobe |
| in_ready | output | 1 | Sender can take a word |
| tx_data | output | W | Sender value wires |
| tx_phase | output | W | Sender toggle wires |
| rx_data | input | W | Receiver value wires |
| rx_phase | input | W | Receiver toggle wires |
| out_word | output | W | Last completed word |
| out_done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach is a word that has only partly arrived, where some bits already show the new parity and others still show the old one. With a direct loopback every bit arrives in the same cycle, so this case never occurs. To reach it, the bench breaks the loopback and copies the sender's wire pairs to the receiver one bit at a time, a few cycles apart and in reverse bit order. After each partial copy it checks that no completion has fired and that ready is still low. Repeated identical words also get their own test, because they move only toggle wires and leave the value wires unchanged.

// File: rtl/ledr_pkg.sv
package ledr_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_WAIT = 1'b1
  } tx_state_t;

  // Toggle-wire level that gives a bit the wanted parity for its value.
  function automatic logic ledr_next_phase(input logic value, input logic parity);
    return value ^ parity;
  endfunction

  // Parity shown on the wires of one bit.
  function automatic logic ledr_bit_parity(input logic d, input logic p);
    return d ^ p;
  endfunction

endpackage

// File: rtl/ledr_tx.sv
module ledr_tx
  import ledr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_word,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         rx_done,
  output logic [W-1:0] tx_data,
  output logic [W-1:0] tx_phase
);

  tx_state_t    state_q;
  logic         par_q;
  logic [W-1:0] data_q;
  logic [W-1:0] phase_q;
  logic [W-1:0] nxt_data;
  logic [W-1:0] nxt_phase;
  logic         accept;
  logic         new_par;

  assign in_ready = (state_q == TX_IDLE);
  assign accept   = in_valid && in_ready;
  assign new_par  = ~par_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt_data[i]  = in_word[i];
    assign nxt_phase[i] = ledr_next_phase(in_word[i], new_par);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      par_q   <= 1'b0;
      data_q  <= '0;
      phase_q <= '0;
    end else if (accept) begin
      state_q <= TX_WAIT;
      par_q   <= new_par;
      data_q  <= nxt_data;
      phase_q <= nxt_phase;
    end else if (state_q == TX_WAIT && rx_done) begin
      state_q <= TX_IDLE;
    end
  end

  assign tx_data  = data_q;
  assign tx_phase = phase_q;

  // R3: exactly one wire of every bit moves per accepted word
  a_r3_one_wire_moves: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (((data_q ^ $past(data_q)) ^ (phase_q ^ $past(phase_q))) == {W{1'b1}}));

  // R2: value wires carry the accepted word
  a_r2_data_is_word: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (data_q == $past(in_word)));

  // R5: sender busy after an accept
  a_r5_not_ready_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R6: wires hold while nothing is accepted
  a_r6_wires_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(data_q) && $stable(phase_q)));

endmodule

// File: rtl/ledr_rx.sv
module ledr_rx
  import ledr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_data,
  input  logic [W-1:0] rx_phase,
  output logic [W-1:0] out_word,
  output logic         out_done
);

  logic         acc_q;
  logic         done_q;
  logic [W-1:0] word_q;
  logic [W-1:0] arrived;
  logic         complete;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign arrived[i] = (ledr_bit_parity(rx_data[i], rx_phase[i]) != acc_q);
  end

  assign complete = &arrived;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
    end else begin
      done_q <= complete;
      if (complete) begin
        acc_q  <= ~acc_q;
        word_q <= rx_data;
      end
    end
  end

  assign out_word = word_q;
  assign out_done = done_q;

  // R8: delivered word holds between completions
  a_r8_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> $stable(word_q));

  // R7: accepted parity moves only on completion
  a_r7_parity_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> (acc_q == $past(acc_q)));

  // R8: a strobe follows every completion
  a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> out_done);

endmodule

// File: rtl/ledr_link.sv
module ledr_link
  import ledr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_word,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] tx_data,
  output logic [W-1:0] tx_phase,
  input  logic [W-1:0] rx_data,
  input  logic [W-1:0] rx_phase,
  output logic [W-1:0] out_word,
  output logic         out_done
);

  logic rx_done;

  ledr_tx #(.W(W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_word  (in_word),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .rx_done  (rx_done),
    .tx_data  (tx_data),
    .tx_phase (tx_phase)
  );

  ledr_rx #(.W(W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_data  (rx_data),
    .rx_phase (rx_phase),
    .out_word (out_word),
    .out_done (rx_done)
  );

  assign out_done = rx_done;

  // R5: ready comes back only after a completion strobe
  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(rx_done));

endmodule

// File: tb/sim_ledr_link.sv
`timescale 1ns/1ps
module sim_ledr_link;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] in_word = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] tx_data, tx_phase;
  logic [W-1:0] rx_data, rx_phase;
  logic [W-1:0] out_word;
  logic out_done;

  logic fwd_mode = 1'b1;
  logic [W-1:0] sk_data = '0;
  logic [W-1:0] sk_phase = '0;

  assign rx_data  = fwd_mode ? tx_data  : sk_data;
  assign rx_phase = fwd_mode ? tx_phase : sk_phase;

  always #2 clk = ~clk;

  ledr_link #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .tx_data(tx_data), .tx_phase(tx_phase),
    .rx_data(rx_data), .rx_phase(rx_phase), .out_word(out_word),
    .out_done(out_done)
  );

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  // bench model of the link state
  logic [W-1:0] m_data = '0;
  logic [W-1:0] m_phase = '0;
  logic m_par = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // accept a word; returns at the negedge after the accepting edge
  task automatic offer(input logic [W-1:0] w);
    logic [W-1:0] pd, pp, ep;
    pd = m_data; pp = m_phase;
    m_par = ~m_par;
    ep = w ^ {W{m_par}};
    in_word = w; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    chk("R2 data wires", tx_data, w);
    chk("R3 one wire per bit", (tx_data ^ pd) ^ (tx_phase ^ pp), {W{1'b1}});
    chk("R3 phase wires", tx_phase, ep);
    chk("R5 ready low after accept", {{(W-1){1'b0}}, in_ready}, '0);
    m_data = w; m_phase = ep;
  endtask

  task automatic t_reset();
    chk("R1 data", tx_data, '0);
    chk("R1 phase", tx_phase, '0);
    chk("R1 out_word", out_word, '0);
    chk("R1 done", {{(W-1){1'b0}}, out_done}, '0);
    chk("R1 ready", {{(W-1){1'b0}}, in_ready}, 1);
  endtask

  // direct loopback transfer
  task automatic t_direct(input logic [W-1:0] w);
    offer(w);
    chk("R7 no done same cycle", {{(W-1){1'b0}}, out_done}, '0);
    step();
    chk("R8 done pulse", {{(W-1){1'b0}}, out_done}, 1);
    chk("R9 word in order", out_word, w);
    chk("R5 ready still low", {{(W-1){1'b0}}, in_ready}, '0);
    step();
    chk("R8 pulse one cycle", {{(W-1){1'b0}}, out_done}, '0);
    chk("R5 ready back", {{(W-1){1'b0}}, in_ready}, 1);
    chk("R8 word held", out_word, w);
  endtask

  task automatic t_repeat(input logic [W-1:0] w);
    logic [W-1:0] ph;
    t_direct(w);
    ph = tx_phase;
    t_direct(w);
    chk("R4 repeat keeps data", tx_data, w);
    chk("R4 repeat inverts phase", tx_phase, ~ph);
  endtask

  task automatic t_skew(input logic [W-1:0] w, input logic [W-1:0] prev);
    sk_data = tx_data; sk_phase = tx_phase;
    fwd_mode = 1'b0;
    offer(w);
    for (int i = W - 1; i >= 0; i--) begin
      sk_data[i] = tx_data[i];
      sk_phase[i] = tx_phase[i];
      if (i != 0) begin
        step(); step();
        chk("R7 partial no done", {{(W-1){1'b0}}, out_done}, '0);
        chk("R7 partial keeps word", out_word, prev);
        chk("R5 ready low while partial", {{(W-1){1'b0}}, in_ready}, '0);
      end
    end
    step();
    chk("R7 done after last bit", {{(W-1){1'b0}}, out_done}, 1);
    chk("R9 skewed word", out_word, w);
    step();
    chk("R5 ready after skew", {{(W-1){1'b0}}, in_ready}, 1);
    fwd_mode = 1'b1;
  endtask

  task automatic t_ignore(input logic [W-1:0] w, input logic [W-1:0] other);
    logic [W-1:0] d, p;
    offer(w);
    d = tx_data; p = tx_phase;
    in_word = other; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    chk("R6 data held", tx_data, d);
    chk("R6 phase held", tx_phase, p);
    chk("R6 word is first", out_word, w);
    step();
    chk("R6 ready back", {{(W-1){1'b0}}, in_ready}, 1);
    chk("R6 still first word", out_word, w);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [W-1:0] w;
    logic [W-1:0] last;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_direct(8'hA5);
    t_direct(8'h3C);
    t_repeat(8'h3C);
    t_direct(8'h00);
    t_direct(8'hFF);
    last = 8'hFF;
    for (int k = 0; k < 12; k++) begin
      w = (k % 3 == 2) ? last : W'($urandom);
      t_direct(w);
      last = w;
    end
    t_skew(8'h96, last);
    t_skew(8'h96, 8'h96);
    t_ignore(8'h5A, 8'hC3);
    t_repeat(8'h5A);
    summary();
  end
endmodule